// File: doc/BRIEF.md
# CRC Accumulate Execution Unit

This unit is the execution stage behind a pair of CRC-update instructions. It takes a 32-bit running checksum, a 64-bit data operand, a width code that picks how many low bytes of that operand take part, and a polynomial select. It returns the updated checksum, sign-extended to 64 bits, ready to be written to a general-purpose register.

The update is a plain reflected CRC register step. The incoming checksum is the starting register value and the final register value is the result. No complement is applied on the way in or on the way out, so a caller that wants a standard finalized CRC applies its own inversions around a chain of these operations.

One parameter selects between two builds. The sequential build handles one byte per clock and holds `busy_o` while it works. The single-cycle build unrolls all eight byte steps and registers the result on the clock edge that accepts the request. Both builds share the same handshake and produce the same results.

Top module: `crcacc_unit`

## Requirements
- R1: `size_i` picks the operand width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. Bytes of `data_i` above the selected width have no effect on the result.
- R2: Operand bytes are folded in little-endian order. Bits `data_i[7:0]` go first, and within each byte the least significant bit goes first.
- R3: With `poly_sel_i` = 0 the reflected polynomial 0xEDB88320 is used. With `poly_sel_i` = 1 the reflected polynomial 0x82F63B78 is used.
- R4: `crc_i` is the starting register and the final register is the result, with no inversion. For example, a start value of 0xFFFFFFFF, four zero bytes and `poly_sel_i` = 0 give 0xDEBB20E3.
- R5: `result_o[63:32]` repeats bit 31 of the 32-bit checksum.
- R6: In the sequential build, `start_i` sampled while idle raises `busy_o` on the next cycle. `done_o` is a one-cycle pulse that appears N clock edges after the accepting edge, where N is the selected byte count. `busy_o` is low while `done_o` is high.
- R7: A `start_i` that arrives while `busy_o` is high has no effect. The computation in progress completes with the operands latched when it was accepted.
- R8: In the single-cycle build, `done_o` pulses on the cycle after each `start_i`. The result it presents matches the sequential build for the same operands.
- R9: After reset, `busy_o` and `done_o` are low and `result_o` is zero.
- R10: `result_o` changes only in a cycle where `done_o` is high. It holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; all operands are sampled with it |
| crc_i | input | 32 | Running checksum fed into the update |
| data_i | input | 64 | Data operand |
| size_i | input | 2 | Width code: 0/1/2/3 for 1/2/4/8 bytes |
| poly_sel_i | input | 1 | 0 picks the 0xEDB88320 polynomial, 1 picks 0x82F63B78 |
| busy_o | output | 1 | Sequential build is working on a request |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Updated checksum, sign-extended |

## Verification
In the sequential build, the result and the `done_o` pulse are due N edges after the edge that samples `start_i`, and `busy_o` is due one edge after it. In the single-cycle build, both the result and `done_o` are due one edge after the request. The bench drives each request on a falling edge and drops `start_i` on the next falling edge. At that point it reads the single-cycle result and the sequential `busy_o`. It then counts falling edges until the sequential `done_o` shows, and checks that count against N. A checker also counts cycles from each accepted request and requires every completion to land exactly on the expected cycle.

// File: rtl/crcacc_pkg.sv
package crcacc_pkg;
  localparam int BYTE_W = 8;
  localparam int SIZE_W = 2;
  localparam int POLY_W = 32;

  localparam logic [POLY_W-1:0] POLY_IEEE_REFL = 32'hEDB88320;
  localparam logic [POLY_W-1:0] POLY_CAST_REFL = 32'h82F63B78;

  typedef enum logic {
    POLY_IEEE = 1'b0,
    POLY_CAST = 1'b1
  } poly_sel_e;
endpackage

// File: rtl/crcacc_byte_step.sv
// One reflected CRC byte update: eight unrolled shift/xor bit steps.
module crcacc_byte_step #(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [CRC_W-1:0]  poly_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_i ^ {{(CRC_W-BYTE_W){1'b0}}, byte_i};

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ poly_i) : (stage[b] >> 1);
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/crcacc_seq_core.sv
// Byte-serial engine: one byte folded per clock, busy between accept and done.
module crcacc_seq_core #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic [CRC_W-1:0]  poly_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CRC_W-1:0]  crc_o
);
  import crcacc_pkg::*;

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [CRC_W-1:0]  acc_q, acc_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic [CRC_W-1:0]  poly_q, poly_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [CRC_W-1:0]  res_q, res_d;
  logic              load_en, step_en, last_step;
  logic [CRC_W-1:0]  step_crc;

  crcacc_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_step (
    .crc_i  (acc_q),
    .byte_i (shf_q[BYTE_W-1:0]),
    .poly_i (poly_q),
    .crc_o  (step_crc)
  );

  assign load_en   = start_i && !busy_q;
  assign step_en   = busy_q;
  assign last_step = busy_q && (left_q == CNT_W'(1));

  always_comb begin
    busy_d = busy_q;
    done_d = last_step;
    acc_d  = acc_q;
    shf_d  = shf_q;
    poly_d = poly_q;
    left_d = left_q;
    res_d  = res_q;
    if (load_en) begin
      busy_d = 1'b1;
      acc_d  = crc_i;
      shf_d  = data_i;
      poly_d = poly_i;
      left_d = nbytes_i;
    end else if (step_en) begin
      acc_d  = step_crc;
      shf_d  = shf_q >> BYTE_W;
      left_d = left_q - CNT_W'(1);
      if (last_step) begin
        busy_d = 1'b0;
        res_d  = step_crc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      acc_q  <= '0;
      shf_q  <= '0;
      poly_q <= '0;
      left_q <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (load_en || step_en) begin
        acc_q  <= acc_d;
        shf_q  <= shf_d;
        poly_q <= poly_d;
        left_q <= left_d;
      end
      if (last_step) res_q <= res_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign crc_o  = res_q;
endmodule

// File: rtl/crcacc_comb_core.sv
// Single-cycle engine: all byte steps unrolled, width-selected tap registered.
module crcacc_comb_core #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic [CRC_W-1:0]  poly_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CRC_W-1:0]  crc_o
);
  import crcacc_pkg::*;

  localparam int NBYTES = DATA_W / BYTE_W;

  logic [CRC_W-1:0] chain [NBYTES+1];
  logic [CRC_W-1:0] pick_d;
  logic [CRC_W-1:0] res_q;
  logic             done_q;

  assign chain[0] = crc_i;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    crcacc_byte_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_step (
      .crc_i  (chain[k]),
      .byte_i (data_i[k*BYTE_W +: BYTE_W]),
      .poly_i (poly_i),
      .crc_o  (chain[k+1])
    );
  end

  always_comb begin
    pick_d = chain[1];
    for (int k = 1; k < NBYTES; k++) begin
      if (nbytes_i == CNT_W'(k + 1)) pick_d = chain[k+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= start_i;
      if (start_i) res_q <= pick_d;
    end
  end

  assign busy_o = 1'b0;
  assign done_o = done_q;
  assign crc_o  = res_q;
endmodule

// File: rtl/crcacc_unit.sv
// CRC accumulate unit: operand masking, polynomial select, engine variant, sign extension.
module crcacc_unit #(
  parameter bit SEQUENTIAL = 1'b1,
  parameter int DATA_W     = 64,
  parameter int CRC_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        size_i,
  input  logic              poly_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  import crcacc_pkg::*;

  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);

  logic [CNT_W-1:0]  nbytes;
  logic [DATA_W-1:0] data_m;
  logic [CRC_W-1:0]  poly;
  logic [CRC_W-1:0]  crc_res;

  assign nbytes = CNT_W'(1) << size_i;
  assign poly   = (poly_sel_e'(poly_sel_i) == POLY_CAST) ? CRC_W'(POLY_CAST_REFL)
                                                         : CRC_W'(POLY_IEEE_REFL);

  for (genvar k = 0; k < NBYTES; k++) begin : g_mask
    assign data_m[k*BYTE_W +: BYTE_W] =
      (CNT_W'(k) < nbytes) ? data_i[k*BYTE_W +: BYTE_W] : '0;
  end

  if (SEQUENTIAL) begin : g_seq
    crcacc_seq_core #(.CRC_W(CRC_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .crc_i    (crc_i),
      .data_i   (data_m),
      .nbytes_i (nbytes),
      .poly_i   (poly),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .crc_o    (crc_res)
    );
  end else begin : g_comb
    crcacc_comb_core #(.CRC_W(CRC_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .crc_i    (crc_i),
      .data_i   (data_m),
      .nbytes_i (nbytes),
      .poly_i   (poly),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .crc_o    (crc_res)
    );
  end

  assign result_o = {{(DATA_W-CRC_W){crc_res[CRC_W-1]}}, crc_res};
endmodule

// File: rtl/crcacc_unit_chk.sv
// Protocol checker for crcacc_unit, attached by bind.
module crcacc_unit_chk #(
  parameter bit SEQUENTIAL = 1'b1,
  parameter int DATA_W     = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        size_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o
);
  logic [4:0] cyc_q;
  logic [4:0] exp_q;
  logic       accept;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      exp_q <= '0;
    end else if (accept) begin
      cyc_q <= 5'd1;
      exp_q <= SEQUENTIAL ? ((5'd1 << size_i) + 5'd1) : 5'd1;
    end else if (cyc_q != 5'd0 && cyc_q != 5'd31) begin
      cyc_q <= cyc_q + 5'd1;
    end
  end

  // R6 / R8: completion lands exactly on the expected cycle after acceptance
  a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc_q == exp_q));

  // R6: done and busy never overlap
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R6: busy persists until the completion pulse
  a_r6_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  // R7 / R8: an accepted request shows up on the next cycle
  a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (SEQUENTIAL ? busy_o : done_o));

  // R10: result moves only together with done
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);
endmodule

bind crcacc_unit crcacc_unit_chk #(.SEQUENTIAL(SEQUENTIAL), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .size_i   (size_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/crcacc_unit_tb.sv
module crcacc_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] crc;
    logic [63:0] data;
    logic [1:0]  size;
    logic        sel;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{32'hFFFFFFFF, 64'h0000000000000000, 2'd2, 1'b0},
    '{32'h00000000, 64'h0000000000000000, 2'd3, 1'b1},
    '{32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b0},
    '{32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 2'd3, 1'b1},
    '{32'h12345678, 64'h0123456789ABCDEF, 2'd0, 1'b0},
    '{32'h12345678, 64'h0123456789ABCDEF, 2'd1, 1'b1},
    '{32'hDEADBEEF, 64'h0123456789ABCDEF, 2'd2, 1'b0},
    '{32'hDEADBEEF, 64'h0123456789ABCDEF, 2'd3, 1'b1},
    '{32'h00000000, 64'hFFFFFFFFFFFFFF80, 2'd0, 1'b1},
    '{32'hA5A5A5A5, 64'h8000000000000001, 2'd3, 1'b0},
    '{32'h00000000, 64'h0000000000000102, 2'd1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] crc;
  logic [63:0] data;
  logic [1:0]  size;
  logic        sel;
  logic        busy_s, done_s, busy_c, done_c;
  logic [63:0] res_s, res_c;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crcacc_unit #(.SEQUENTIAL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .crc_i(crc), .data_i(data),
    .size_i(size), .poly_sel_i(sel), .busy_o(busy_s), .done_o(done_s), .result_o(res_s)
  );

  crcacc_unit #(.SEQUENTIAL(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .start_i(start), .crc_i(crc), .data_i(data),
    .size_i(size), .poly_sel_i(sel), .busy_o(busy_c), .done_o(done_c), .result_o(res_c)
  );

  // Bit-serial reference: one data bit per step, LSB first.
  function automatic logic [63:0] ref_crc(input vec_t v);
    logic [31:0] c = v.crc;
    logic [31:0] p = v.sel ? 32'h82F63B78 : 32'hEDB88320;
    int nbits = 8 << v.size;
    for (int i = 0; i < nbits; i++) begin
      logic fb = c[0] ^ v.data[i];
      c = c >> 1;
      if (fb) c = c ^ p;
    end
    return {{32{c[31]}}, c};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    crc = v.crc; data = v.data; size = v.size; sel = v.sel;
  endtask

  // Issues one request; returns both results and the sequential latency.
  task automatic run_vec(input vec_t v, output logic [63:0] rs, output logic [63:0] rc,
                         output int lat);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rc = res_c;
    check("R8 comb done", {63'd0, done_c}, 64'd1);
    check("R6 busy after accept", {63'd0, busy_s}, 64'd1);
    lat = 0;
    while (!done_s && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rs = res_s;
    check("R6 busy low at done", {63'd0, busy_s}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] rs, rc, hold, ra;
    int lat;
    rst_n = 1'b0; start = 1'b0; crc = '0; data = '0; size = '0; sel = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", {63'd0, busy_s}, 64'd0);
    check("R9 done", {63'd0, done_s}, 64'd0);
    check("R9 result", res_s, 64'd0);
    check("R9 comb result", res_c, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R8: vector walk against the reference
    for (int i = 0; i < NVEC; i++) begin
      run_vec(VECS[i], rs, rc, lat);
      check($sformatf("R1/R2/R3 seq vec%0d", i), rs, ref_crc(VECS[i]));
      check($sformatf("R8 comb vec%0d", i), rc, ref_crc(VECS[i]));
      check($sformatf("R6 latency vec%0d", i), 64'(lat), 64'(1 << VECS[i].size));
    end

    // R4: raw update with no inversion, known value
    run_vec('{32'hFFFFFFFF, 64'h0, 2'd2, 1'b0}, rs, rc, lat);
    check("R4 raw value", rs, 64'hFFFFFFFF_DEBB20E3);
    // R5: upper half mirrors bit 31
    check("R5 sign ext", rs[63:32], {32{rs[31]}});

    // R1: bytes above width ignored (compare at ports)
    run_vec('{32'h13579BDF, 64'h00000000000000C3, 2'd0, 1'b1}, ra, rc, lat);
    run_vec('{32'h13579BDF, 64'h5AA5F00F123456C3, 2'd0, 1'b1}, rs, rc, lat);
    check("R1 upper bytes ignored", rs, ra);

    // R2: byte order matters
    run_vec('{32'h0, 64'h0000000000000201, 2'd1, 1'b0}, ra, rc, lat);
    run_vec('{32'h0, 64'h0000000000000102, 2'd1, 1'b0}, rs, rc, lat);
    check("R2 order sensitive", {63'd0, (rs != ra)}, 64'd1);

    // R3: polynomials differ on same operands
    run_vec('{32'h0, 64'h00000000000000FF, 2'd0, 1'b0}, ra, rc, lat);
    run_vec('{32'h0, 64'h00000000000000FF, 2'd0, 1'b1}, rs, rc, lat);
    check("R3 poly0", ra, ref_crc('{32'h0, 64'hFF, 2'd0, 1'b0}));
    check("R3 poly1", rs, ref_crc('{32'h0, 64'hFF, 2'd0, 1'b1}));

    // R7: start while busy ignored by the sequential build
    @(negedge clk);
    drive(VECS[6]);
    start = 1'b1;
    @(negedge clk);
    drive(VECS[7]);
    start = 1'b1;
    check("R7 busy during second start", {63'd0, busy_s}, 64'd1);
    @(negedge clk);
    start = 1'b0;
    check("R8 comb took second request", res_c, ref_crc(VECS[7]));
    lat = 0;
    while (!done_s && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R7 first operands kept", res_s, ref_crc(VECS[6]));
    check("R7 latency unchanged", 64'(lat + 1), 64'(1 << VECS[6].size));
    hold = res_s;

    // R10: result holds and done is a single pulse
    @(negedge clk);
    check("R6 done one cycle", {63'd0, done_s}, 64'd0);
    drive(VECS[2]);
    repeat (3) @(negedge clk);
    check("R10 result held", res_s, hold);
    check("R10 still idle", {63'd0, busy_s}, 64'd0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule